// File: doc/BRIEF.md
# Pattern Pulse Train Generator

This block drives one serial output pin from a programmable bit pattern. The pattern is sent least significant bit first, one bit per bit-rate tick. It can be sent a set number of times, with an idle-low gap of a set number of bit periods between sends. It can also be sent without end. A second mode turns the pin into a square wave whose half period is a whole number of ticks.

The block copies its configuration when a run starts, so later writes to the configuration have no effect until the next start. A run starts when `enable` is high and the channel is idle. A finite run ends with a one-cycle `loop_done` pulse. After that the channel stays stopped until `enable` goes low and then high again. The tick input comes from an external divider, so the bit rate is set outside the block.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, `pin_out`, `running`, `loop_done` and `cfg_err` are all 0.
- R2: In pattern mode the first clock edge with `enable` high and the channel idle starts a run. From the next cycle `running` is 1 and `pin_out` shows pattern bit 0. Each `bit_tick` moves to the next higher bit. Without a tick, `pin_out` holds its value.
- R3: The length code `cfg_len` selects how many bits are sent: code 0 sends all 32 bits, and a code N of 2 or more sends bits 0 to N-1.
- R4: Length code 1 is treated as 2 bits, and a run started with it in pattern mode sets `cfg_err`. Only reset clears `cfg_err`, and it stays 0 for runs started with any other code.
- R5: Between two sends of the pattern, `pin_out` is low for exactly `cfg_gap` tick periods. No gap follows the last send, and a gap of 0 places sends back to back.
- R6: With a nonzero `cfg_loops`, the tick that ends the last send raises `loop_done` for exactly one cycle, starting with the next cycle. In that same cycle `running` and `pin_out` drop to 0. The channel then stays stopped while `enable` stays high.
- R7: With `cfg_loops` equal to 0, the pattern repeats until `enable` goes low.
- R8: One clock edge after `enable` goes low, `running` and `pin_out` are 0. A later start begins again at bit 0 of the first send.
- R9: Configuration is captured when a run starts. Changing any `cfg_*` input during a run does not change the output.
- R10: With `cfg_square` at 1, a start drives `pin_out` high. The pin then toggles on every (`cfg_half`+1)-th tick, and `cfg_loops` and `cfg_gap` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| enable | input | 1 | Level run request |
| cfg_square | input | 1 | 1 = square wave, 0 = pattern |
| cfg_pattern | input | 32 | Bit pattern, bit 0 sent first |
| cfg_len | input | 5 | Length code (0 = 32, 1 = invalid, N = N bits) |
| cfg_loops | input | 16 | Number of sends, 0 = endless |
| cfg_gap | input | 16 | Idle tick periods between sends |
| cfg_half | input | 16 | Square-wave half period minus one, in ticks |
| pin_out | output | 1 | Serial output |
| running | output | 1 | Channel active |
| loop_done | output | 1 | One-cycle pulse when a finite run ends |
| cfg_err | output | 1 | Sticky invalid-length flag |

## Verification
Every result appears one clock edge after its cause, because the pin is decoded directly from registers that update on the start edge, the tick edge or the edge where `enable` goes low. The bench drives inputs on the falling edge and samples on the next falling edge, which is the first point where each result can be seen. `loop_done` is read in the cycle just after the final tick. It is checked again one cycle later to confirm that the pulse lasts one cycle. After each tick the bench waits one idle cycle, which shows that the pin holds between ticks.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic {
    PH_BITS = 1'b0,
    PH_GAP  = 1'b1
  } ptg_phase_e;

  typedef enum logic {
    MODE_PATTERN = 1'b0,
    MODE_SQUARE  = 1'b1
  } ptg_mode_e;
endpackage

// File: rtl/ptg_cfg_hold.sv
module ptg_cfg_hold #(
  parameter int PAT_W  = 32,
  parameter int LEN_W  = 5,
  parameter int LOOP_W = 16,
  parameter int GAP_W  = 16,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_square,
  input  logic [PAT_W-1:0]  in_pattern,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [LOOP_W-1:0] in_loops,
  input  logic [GAP_W-1:0]  in_gap,
  input  logic [HALF_W-1:0] in_half,
  output ptg_pkg::ptg_mode_e mode_q,
  output logic [PAT_W-1:0]  pat_q,
  output logic [LEN_W:0]    nbits_q,
  output logic [LOOP_W-1:0] loops_q,
  output logic [GAP_W-1:0]  gap_q,
  output logic [HALF_W-1:0] half_q,
  output logic              err_q
);
  import ptg_pkg::*;

  // Length decode: code 0 selects the full width, code 1 falls back to two bits.
  function automatic logic [LEN_W:0] decode_len(input logic [LEN_W-1:0] code);
    if (code == '0)      return (LEN_W+1)'(PAT_W);
    else if (code == 1)  return (LEN_W+1)'(2);
    else                 return {1'b0, code};
  endfunction

  wire bad_code = (in_len == LEN_W'(1)) && !in_square;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PATTERN;
      pat_q   <= '0;
      nbits_q <= (LEN_W+1)'(PAT_W);
      loops_q <= '0;
      gap_q   <= '0;
      half_q  <= '0;
      err_q   <= 1'b0;
    end else if (load) begin
      mode_q  <= in_square ? MODE_SQUARE : MODE_PATTERN;
      pat_q   <= in_pattern;
      nbits_q <= decode_len(in_len);
      loops_q <= in_loops;
      gap_q   <= in_gap;
      half_q  <= in_half;
      if (bad_code) err_q <= 1'b1;
    end
  end

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r3_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (nbits_q >= 2) && (nbits_q <= PAT_W));
endmodule

// File: rtl/ptg_pattern_seq.sv
module ptg_pattern_seq #(
  parameter int PAT_W  = 32,
  parameter int LEN_W  = 5,
  parameter int LOOP_W = 16,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              go,
  input  logic              tick,
  input  logic [PAT_W-1:0]  pat,
  input  logic [LEN_W:0]    nbits,
  input  logic [LOOP_W-1:0] loops,
  input  logic [GAP_W-1:0]  gap,
  output logic              bit_val,
  output logic              in_gap,
  output logic              exit_evt
);
  import ptg_pkg::*;

  ptg_phase_e        phase_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LOOP_W-1:0] sent_q;
  logic [GAP_W-1:0]  gcnt_q;

  wire step      = go && tick;
  wire last_bit  = ((LEN_W+1)'(idx_q) + (LEN_W+1)'(1)) == nbits;
  wire last_gap  = (gcnt_q + GAP_W'(1)) == gap;
  wire finite    = (loops != '0);
  wire last_send = finite && ((sent_q + LOOP_W'(1)) == loops);
  wire send_end  = step && (phase_q == PH_BITS) && last_bit;

  assign exit_evt = send_end && last_send;
  assign in_gap   = (phase_q == PH_GAP);
  assign bit_val  = !in_gap && pat[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BITS;
      idx_q   <= '0;
      sent_q  <= '0;
      gcnt_q  <= '0;
    end else if (restart) begin
      phase_q <= PH_BITS;
      idx_q   <= '0;
      sent_q  <= '0;
      gcnt_q  <= '0;
    end else if (step) begin
      if (phase_q == PH_BITS) begin
        if (!last_bit) begin
          idx_q <= idx_q + LEN_W'(1);
        end else begin
          idx_q <= '0;
          if (finite) sent_q <= sent_q + LOOP_W'(1);
          if (gap != '0 && !last_send) begin
            phase_q <= PH_GAP;
            gcnt_q  <= '0;
          end
        end
      end else begin
        if (last_gap) begin
          phase_q <= PH_BITS;
          gcnt_q  <= '0;
        end else begin
          gcnt_q <= gcnt_q + GAP_W'(1);
        end
      end
    end
  end

  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ((LEN_W+1)'(idx_q) < nbits));
  a_r5_gap_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (idx_q == '0));
  a_r5_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (go && in_gap) |-> (gcnt_q < gap));
endmodule

// File: rtl/ptg_square.sv
module ptg_square #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              go,
  input  logic              tick,
  input  logic [HALF_W-1:0] half,
  output logic              level
);
  logic [HALF_W-1:0] div_q;
  wire flip = go && tick && (div_q == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      level <= 1'b0;
    end else if (restart) begin
      div_q <= '0;
      level <= 1'b1;
    end else if (go && tick) begin
      if (flip) begin
        div_q <= '0;
        level <= !level;
      end else begin
        div_q <= div_q + HALF_W'(1);
      end
    end
  end

  a_r10_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (div_q <= half));
  a_r10_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !tick && !restart) |=> $stable(level));
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int PAT_W  = 32,
  parameter int LOOP_W = 16,
  parameter int GAP_W  = 16,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              enable,
  input  logic              cfg_square,
  input  logic [PAT_W-1:0]  cfg_pattern,
  input  logic [$clog2(PAT_W)-1:0] cfg_len,
  input  logic [LOOP_W-1:0] cfg_loops,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [HALF_W-1:0] cfg_half,
  output logic              pin_out,
  output logic              running,
  output logic              loop_done,
  output logic              cfg_err
);
  import ptg_pkg::*;

  localparam int LEN_W = $clog2(PAT_W);

  logic active_q, parked_q, done_q;

  ptg_mode_e         mode_q;
  logic [PAT_W-1:0]  pat_q;
  logic [LEN_W:0]    nbits_q;
  logic [LOOP_W-1:0] loops_q;
  logic [GAP_W-1:0]  gap_q;
  logic [HALF_W-1:0] half_q;
  logic              seq_bit, seq_gap, seq_exit, sq_level;

  // Named events for the checks and the sub-blocks.
  wire start_evt = enable && !active_q && !parked_q;
  wire pat_go    = enable && active_q && (mode_q == MODE_PATTERN);
  wire sq_go     = enable && active_q && (mode_q == MODE_SQUARE);
  wire finish    = pat_go && seq_exit;

  ptg_cfg_hold #(
    .PAT_W(PAT_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W), .GAP_W(GAP_W), .HALF_W(HALF_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(start_evt),
    .in_square(cfg_square), .in_pattern(cfg_pattern), .in_len(cfg_len),
    .in_loops(cfg_loops), .in_gap(cfg_gap), .in_half(cfg_half),
    .mode_q(mode_q), .pat_q(pat_q), .nbits_q(nbits_q), .loops_q(loops_q),
    .gap_q(gap_q), .half_q(half_q), .err_q(cfg_err)
  );

  ptg_pattern_seq #(
    .PAT_W(PAT_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W), .GAP_W(GAP_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .restart(start_evt || !enable), .go(pat_go),
    .tick(bit_tick), .pat(pat_q), .nbits(nbits_q), .loops(loops_q), .gap(gap_q),
    .bit_val(seq_bit), .in_gap(seq_gap), .exit_evt(seq_exit)
  );

  ptg_square #(.HALF_W(HALF_W)) sq_i (
    .clk(clk), .rst_n(rst_n), .restart(start_evt), .go(sq_go),
    .tick(bit_tick), .half(half_q), .level(sq_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      parked_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (!enable) begin
        active_q <= 1'b0;
        parked_q <= 1'b0;
      end else if (start_evt) begin
        active_q <= 1'b1;
      end else if (finish) begin
        active_q <= 1'b0;
        parked_q <= 1'b1;
      end
    end
  end

  assign running   = active_q;
  assign loop_done = done_q;
  assign pin_out   = active_q && ((mode_q == MODE_SQUARE) ? sq_level : seq_bit);

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !loop_done);
  a_r6_done_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> (!running && !pin_out));
  a_r6_parked_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_done && enable) |=> !running);
  a_r8_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!running && !pin_out));
  a_r5_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode_q == MODE_PATTERN && seq_gap) |-> !pin_out);
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && !bit_tick) |=> $stable(pin_out));
endmodule

// File: tb/pulse_train_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_train_gen_tb_top;
  logic        clk = 0, rst_n = 0, bit_tick = 0, enable = 0, cfg_square = 0;
  logic [31:0] cfg_pattern = 0;
  logic [4:0]  cfg_len = 0;
  logic [15:0] cfg_loops = 0, cfg_gap = 0, cfg_half = 0;
  logic        pin_out, running, loop_done, cfg_err;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic ld_seen;

  always #5 clk = ~clk;

  pulse_train_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .enable(enable),
    .cfg_square(cfg_square), .cfg_pattern(cfg_pattern), .cfg_len(cfg_len),
    .cfg_loops(cfg_loops), .cfg_gap(cfg_gap), .cfg_half(cfg_half),
    .pin_out(pin_out), .running(running), .loop_done(loop_done), .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Tick edge falls between two negedges; loop_done is captured right after it,
  // then one idle cycle follows so the pin must hold.
  task automatic tick();
    bit_tick = 1;
    @(negedge clk);
    bit_tick = 0;
    ld_seen = loop_done;
    @(negedge clk);
  endtask

  task automatic start_ch();
    enable = 1;
    @(negedge clk);
  endtask

  task automatic stop_ch();
    enable = 0;
    @(negedge clk);
  endtask

  function automatic int eff_len(logic [4:0] code);
    if (code == 0) return 32;
    if (code == 1) return 2;
    return code;
  endfunction

  task automatic t_pattern(logic [31:0] pat, logic [4:0] code, int loops, int gap,
                           bit scramble, string tag);
    int n;
    cfg_square = 0; cfg_pattern = pat; cfg_len = code;
    cfg_loops = 16'(loops); cfg_gap = 16'(gap);
    start_ch();
    if (scramble) begin  // R9: inputs changed after the start edge
      cfg_pattern = ~pat; cfg_len = 5'd3; cfg_loops = 16'd0; cfg_gap = 16'd7;
    end
    chk({tag, " R2 running"}, running, 1);
    n = eff_len(code);
    for (int r = 0; r < loops; r++) begin
      for (int b = 0; b < n; b++) begin
        chk({tag, " R2/R3 bit"}, pin_out, pat[b]);
        tick();
        if (r == loops - 1 && b == n - 1) chk({tag, " R6 done pulse"}, ld_seen, 1);
        else                              chk({tag, " R6 no early done"}, ld_seen, 0);
      end
      if (r != loops - 1)
        for (int g = 0; g < gap; g++) begin
          chk({tag, " R5 gap low"}, pin_out, 0);
          tick();
        end
    end
    chk({tag, " R6 done one cycle"}, loop_done, 0);
    chk({tag, " R6 stopped"}, running, 0);
    chk({tag, " R6 pin low"}, pin_out, 0);
    repeat (3) @(negedge clk);
    chk({tag, " R6 parked while enabled"}, running, 0);
    stop_ch();
  endtask

  task automatic t_reset();
    chk("R1 pin", pin_out, 0);
    chk("R1 running", running, 0);
    chk("R1 loop_done", loop_done, 0);
    chk("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_continuous();
    logic [31:0] pat = 32'h9;
    cfg_square = 0; cfg_pattern = pat; cfg_len = 5'd4; cfg_loops = 0; cfg_gap = 1;
    start_ch();
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < 4; b++) begin
        chk("R7 bit", pin_out, pat[b]);
        tick();
        chk("R7 no exit", ld_seen, 0);
      end
      chk("R7 gap", pin_out, 0);
      tick();
    end
    chk("R7 still running", running, 1);
    tick(); tick();
    chk("R8 mid bit", pin_out, pat[2]);
    stop_ch();
    chk("R8 stopped", running, 0);
    chk("R8 pin low", pin_out, 0);
    start_ch();
    chk("R8 restart at bit 0", pin_out, pat[0]);
    tick();
    chk("R8 restart bit 1", pin_out, pat[1]);
    stop_ch();
  endtask

  task automatic t_square();
    bit lvl;
    cfg_square = 1; cfg_half = 16'd2; cfg_loops = 16'd1; cfg_gap = 16'd5;
    start_ch();
    chk("R10 starts high", pin_out, 1);
    for (int k = 1; k <= 10; k++) begin
      tick();
      lvl = ((k / 3) % 2) == 0;
      chk("R10 level", pin_out, lvl);
      chk("R10 ignores loops", ld_seen, 0);
    end
    chk("R10 still running", running, 1);
    chk("R4 square no err", cfg_err, 0);
    stop_ch();
    chk("R8 square stop", pin_out, 0);
  endtask

  task automatic t_bad_len();
    t_pattern(32'h1, 5'd1, 1, 0, 0, "code1");
    chk("R4 err set", cfg_err, 1);
    repeat (2) @(negedge clk);
    chk("R4 err sticky", cfg_err, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_pattern(32'h0000_00A5, 5'd8, 2, 3, 0, "a5");
    t_pattern(32'h8001_4003, 5'd0, 1, 0, 0, "full32");
    t_pattern(32'h0000_0005, 5'd3, 3, 0, 0, "nogap");
    chk("R4 no err for legal codes", cfg_err, 0);
    t_continuous();
    t_pattern(32'h0000_0002, 5'd2, 2, 1, 1, "R9 scramble");
    t_square();
    t_bad_len();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule